// File: doc/BRIEF.md
# RGB Colour Correction Matrix

The block applies a 3x3 colour correction matrix, three per-channel offsets and an optional video-range clamp to a stream of 8-bit RGB pixels. Every pixel carries the number of the display FIFO it belongs to. Only one of the three FIFOs can be corrected at any time. A 2-bit select field names that FIFO, and the value 0 turns the matrix off. Pixels from any other FIFO come out unchanged after the same single cycle of latency.

Configuration uses four 32-bit words written through a simple write port. These are three coefficient words and one word that holds the offsets, the FIFO select and the clamp control. Writes go into shadow registers. The shadow contents move to the active set only on a frame-start pulse, so a frame is never processed with a half-written matrix.

The block also has a combinational helper. It turns a 64-bit sign-magnitude S31.32 number into the 10-bit coefficient format, saturating any magnitude that has integer bits.

Top module: `ctm_xform`

## Requirements
- R1: After reset all outputs are zero and every configuration word is zero. The matrix is therefore disabled, and pixels pass unchanged.
- R2: A pixel passes with its R, G and B values unchanged in these cases: the select field (control word bits [25:24]) is 0, or the pixel's FIFO number differs from select minus 1. FIFO number 3 never matches.
- R3: Each coefficient is 10-bit sign-magnitude S0.9: bit 9 is the sign and bits [8:0] are the magnitude in 512ths. Word address 2 holds the coefficients for the red input, address 1 for green and address 0 for blue. In each word, bits [29:20] feed red out, [19:10] feed green out and [9:0] feed blue out. Output channel = sum of input times coefficient.
- R4: Control word (address 3) bits [23:16], [15:8] and [7:0] are two's-complement offsets for red, green and blue. Each offset is added in whole output steps before rounding.
- R5: The sum is rounded half-up: add 0.5, then take the floor. The result is then saturated to [0,255].
- R6: When control bit 31 is set, a matched pixel's red is limited to [16,235] and its green and blue to [16,240]. The limiting is done after saturation.
- R7: Writes change only the shadow words. The active words take the shadow contents on a frame_start pulse and hold them at all other times.
- R8: A write in the same cycle as frame_start is not part of that transfer. It takes effect at the following frame_start.
- R9: conv_out[9] equals conv_in[63]. conv_out[8:0] is all ones if any of conv_in[62:32] is set, and conv_in[31:23] otherwise.
- R10: out_valid and out_fifo repeat in_valid and in_fifo one clock later, and the pixel data has the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word address: 0..2 coefficients, 3 control |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Copies shadow words to the active set |
| in_valid | input | 1 | Input pixel valid |
| in_fifo | input | 2 | FIFO number of the input pixel |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_fifo | output | 2 | FIFO number of the output pixel |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |
| conv_in | input | 64 | S31.32 sign-magnitude value |
| conv_out | output | 10 | Converted S0.9 coefficient |

## Verification
A wrong active word appears on the very next matched pixel, one clock after that pixel enters. It shows as a wrong channel value, a wrong channel order or a missed offset sign. A shadow word that leaks into the active set early shows on the first pixel after the write, before any frame_start. A missed transfer shows on the first pixel after the pulse. A wrong FIFO match shows immediately in two ways: matched pixels pass through unchanged, or pixels from the wrong FIFO get transformed.

// File: rtl/ctm_pkg.sv
`timescale 1ns/1ps
package ctm_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 10;
  localparam int FRAC_W    = COEF_W - 1;
  localparam int OFF_W     = 8;
  localparam int SEL_W     = 2;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int NUM_CH    = 3;
  localparam int ACC_W     = PIX_W + FRAC_W + 4;
  localparam int CTL_IDX   = 3;
  localparam int SEL_LSB   = 24;
  localparam int CLAMP_BIT = 31;
  localparam int CLAMP_LO  = 16;
  localparam int HI_RED    = 235;
  localparam int HI_CHROMA = 240;

  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] PIX_MAX  = ACC_W'((1 << PIX_W) - 1);

  // signed product of one pixel component with a sign-magnitude coefficient
  function automatic logic signed [ACC_W-1:0] mac_term(input logic [PIX_W-1:0] p,
                                                       input logic [COEF_W-1:0] c);
    logic [ACC_W-1:0] mag;
    mag = ACC_W'(p) * ACC_W'(c[FRAC_W-1:0]);
    return c[COEF_W-1] ? -$signed(mag) : $signed(mag);
  endfunction

  // round half up, then saturate to the pixel range
  function automatic logic [PIX_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] q;
    q = (acc + RND_HALF) >>> FRAC_W;
    if (q < 0) return '0;
    if (q > PIX_MAX) return '1;
    return q[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] range_limit(input logic [PIX_W-1:0] v,
                                                   input logic [PIX_W-1:0] lo,
                                                   input logic [PIX_W-1:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // 64-bit sign-magnitude S31.32 to S0.9 with saturation
  function automatic logic [COEF_W-1:0] s31_to_s09(input logic [63:0] v);
    logic [FRAC_W-1:0] mag;
    mag = (|v[62:32]) ? '1 : v[31:32-FRAC_W];
    return {v[63], mag};
  endfunction
endpackage

// File: rtl/ctm_regs.sv
`timescale 1ns/1ps
module ctm_regs import ctm_pkg::*; (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  input  logic                             frame_start,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] act_words
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] shd_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] act_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_q[w] <= '0;
        act_q[w] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(w)) shd_q[w] <= wr_data;
        if (frame_start) act_q[w] <= shd_q[w];
      end
    end
  end

  assign act_words = act_q;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_q)); // R7
  AST_ACT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> act_q == $past(shd_q)); // R8
  AST_SHD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shd_q)); // R7
endmodule

// File: rtl/ctm_channel.sv
`timescale 1ns/1ps
module ctm_channel import ctm_pkg::*; #(
  parameter int HI_LIM = HI_CHROMA
) (
  input  logic [NUM_CH-1:0][PIX_W-1:0]  pix,
  input  logic [NUM_CH-1:0][COEF_W-1:0] coef,
  input  logic [OFF_W-1:0]              off,
  input  logic                          clamp_en,
  output logic [PIX_W-1:0]              y
);
  logic signed [ACC_W-1:0] off_ext;
  logic signed [ACC_W-1:0] acc;
  logic [PIX_W-1:0]        sat_v;

  assign off_ext = $signed({{(ACC_W-OFF_W){off[OFF_W-1]}}, off});

  always_comb begin
    acc = off_ext <<< FRAC_W;
    for (int i = 0; i < NUM_CH; i++) acc = acc + mac_term(pix[i], coef[i]);
    sat_v = round_sat(acc);
    y = clamp_en ? range_limit(sat_v, PIX_W'(CLAMP_LO), PIX_W'(HI_LIM)) : sat_v;
  end
endmodule

// File: rtl/ctm_s09_conv.sv
`timescale 1ns/1ps
module ctm_s09_conv import ctm_pkg::*; (
  input  logic [63:0]       wide_in,
  output logic [COEF_W-1:0] coef_out
);
  assign coef_out = s31_to_s09(wide_in);
endmodule

// File: rtl/ctm_xform.sv
`timescale 1ns/1ps
module ctm_xform import ctm_pkg::*; #(
  parameter int NUM_FIFO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  in_fifo,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic [SEL_W-1:0]  out_fifo,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b,
  input  logic [63:0]       conv_in,
  output logic [COEF_W-1:0] conv_out
);
  logic [NUM_WORDS-1:0][WORD_W-1:0]         act_words;
  logic [WORD_W-1:0]                        ctl;
  logic [SEL_W-1:0]                         sel;
  logic                                     clamp_en;
  logic [NUM_CH-1:0][PIX_W-1:0]             pix;
  logic [NUM_CH-1:0][PIX_W-1:0]             xf;
  logic [NUM_CH-1:0][NUM_CH-1:0][COEF_W-1:0] coef; // [out][in]
  logic                                     hit;
  logic                                     hit_q;
  logic                                     clamp_q;
  logic                                     unused_bits;

  ctm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .frame_start(frame_start), .act_words(act_words)
  );

  assign ctl      = act_words[CTL_IDX];
  assign sel      = ctl[SEL_LSB +: SEL_W];
  assign clamp_en = ctl[CLAMP_BIT];
  assign unused_bits = ^{ctl[30:26], act_words[0][31:30], act_words[1][31:30], act_words[2][31:30]};

  assign pix[0] = in_r;
  assign pix[1] = in_g;
  assign pix[2] = in_b;

  for (genvar o = 0; o < NUM_CH; o++) begin : g_out
    for (genvar i = 0; i < NUM_CH; i++) begin : g_in
      // input red lives in word 2, blue in word 0; output red in the top field
      assign coef[o][i] = act_words[NUM_CH-1-i][(NUM_CH-1-o)*COEF_W +: COEF_W];
    end
    ctm_channel #(.HI_LIM(o == 0 ? HI_RED : HI_CHROMA)) u_ch (
      .pix(pix), .coef(coef[o]), .off(ctl[(NUM_CH-1-o)*OFF_W +: OFF_W]),
      .clamp_en(clamp_en), .y(xf[o])
    );
  end

  assign hit = in_valid && (sel != '0) && (int'(sel) <= NUM_FIFO) &&
               (in_fifo == sel - SEL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fifo  <= '0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
      hit_q     <= 1'b0;
      clamp_q   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      hit_q     <= hit;
      clamp_q   <= clamp_en;
      if (in_valid) begin
        out_fifo <= in_fifo;
        out_r    <= hit ? xf[0] : in_r;
        out_g    <= hit ? xf[1] : in_g;
        out_b    <= hit ? xf[2] : in_b;
      end
    end
  end

  ctm_s09_conv u_conv (.wide_in(conv_in), .coef_out(conv_out));

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit) |=> (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b))); // R2
  AST_CLAMP_RED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hit_q && clamp_q) |-> (out_r >= 8'd16 && out_r <= 8'd235)); // R6
  AST_CLAMP_GB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hit_q && clamp_q) |-> (out_g >= 8'd16 && out_g <= 8'd240 && out_b >= 8'd16 && out_b <= 8'd240)); // R6
  AST_TAG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_fifo == $past(in_fifo))); // R10
  AST_NO_MATCH_FIFO3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fifo == 2'd3) |=> !hit_q); // R2
  AST_CONV_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_in[62:32] != '0) |-> (conv_out[8:0] == 9'h1FF && conv_out[9] == conv_in[63])); // R9
endmodule

// File: tb/ctm_xform_tb.sv
`timescale 1ns/1ps
module ctm_xform_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        frame_start = 0;
  logic        in_valid = 0;
  logic [1:0]  in_fifo = 0;
  logic [7:0]  in_r = 0, in_g = 0, in_b = 0;
  logic        out_valid;
  logic [1:0]  out_fifo;
  logic [7:0]  out_r, out_g, out_b;
  logic [63:0] conv_in = 0;
  logic [9:0]  conv_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_shd [4];
  logic [31:0] m_act [4];

  always #2.5 clk = ~clk;

  ctm_xform dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_fifo(in_fifo), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_fifo(out_fifo), .out_r(out_r), .out_g(out_g),
    .out_b(out_b), .conv_in(conv_in), .conv_out(conv_out)
  );

  function automatic int model_chan(int c, int r, int g, int b);
    int px [3];
    int acc, off, q, w, fld, v;
    px[0] = r; px[1] = g; px[2] = b;
    acc = 0;
    for (int j = 0; j < 3; j++) begin
      w   = int'(m_act[2-j]);
      fld = (w >> (20 - 10*c)) & 1023;
      v   = fld & 511;
      if ((fld & 512) != 0) v = -v;
      acc += px[j] * v;
    end
    off = (int'(m_act[3]) >> (16 - 8*c)) & 255;
    if (off >= 128) off -= 256;
    acc += off * 512 + 256;
    q = (acc >= 0) ? acc / 512 : -((-acc + 511) / 512);
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    if (m_act[3][31]) begin
      if (q < 16) q = 16;
      if (c == 0 && q > 235) q = 235;
      if (c != 0 && q > 240) q = 240;
    end
    return q;
  endfunction

  function automatic logic [9:0] model_conv(logic [63:0] v);
    logic [62:0] mag;
    mag = v[62:0];
    if (mag >= 63'h1_0000_0000) return {v[63], 9'h1FF};
    return {v[63], mag[31:23]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit with_frame);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d; frame_start = with_frame;
    @(negedge clk);
    cfg_wr_en = 0; frame_start = 0;
    if (with_frame) for (int k = 0; k < 4; k++) m_act[k] = m_shd[k];
    m_shd[a] = d;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    for (int k = 0; k < 4; k++) m_act[k] = m_shd[k];
  endtask

  task automatic pix(input logic [1:0] f, input int r, input int g, input int b, input string tag);
    int er, eg, eb;
    int sel;
    bit match;
    sel = int'(m_act[3][25:24]);
    match = (sel != 0) && (int'(f) == sel - 1);
    er = match ? model_chan(0, r, g, b) : r;
    eg = match ? model_chan(1, r, g, b) : g;
    eb = match ? model_chan(2, r, g, b) : b;
    @(negedge clk);
    in_valid = 1; in_fifo = f; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    @(negedge clk);
    in_valid = 0;
    n_chk++;
    if (!(out_valid === 1'b1 && out_fifo === f && int'(out_r) == er &&
          int'(out_g) == eg && int'(out_b) == eb)) begin
      n_bad++;
      $display("FAIL %s: got v=%0d f=%0d rgb=%0d,%0d,%0d exp v=1 f=%0d rgb=%0d,%0d,%0d",
               tag, out_valid, out_fifo, out_r, out_g, out_b, f, er, eg, eb);
    end
  endtask

  task automatic conv(input logic [63:0] v);
    logic [9:0] e;
    e = model_conv(v);
    conv_in = v;
    @(negedge clk);
    n_chk++;
    if (conv_out !== e) begin
      n_bad++;
      $display("FAIL R9 conv %h: got %h exp %h", v, conv_out, e);
    end
  endtask

  function automatic logic [31:0] cw(int c0, int c1, int c2);
    return {2'b00, 10'(c0), 10'(c1), 10'(c2)};
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin m_shd[k] = 0; m_act[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_r !== 8'd0 || out_g !== 8'd0 || out_b !== 8'd0 || out_fifo !== 2'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%0d rgb=%0d,%0d,%0d exp all zero", out_valid, out_r, out_g, out_b);
    end
    pix(2'd0, 200, 100, 50, "R1 disabled after reset");
    frame();
    pix(2'd1, 9, 8, 7, "R1 still disabled after frame");

    // near-identity on FIFO 1 (select 2)
    wr(2'd2, cw(511, 0, 0), 0);
    wr(2'd1, cw(0, 511, 0), 0);
    wr(2'd0, cw(0, 0, 511), 0);
    wr(2'd3, 32'h0200_0000, 0);
    pix(2'd1, 255, 128, 1, "R7 shadow not active yet");
    frame();
    pix(2'd1, 255, 128, 1, "R3 diagonal");
    pix(2'd0, 255, 128, 1, "R2 other fifo");
    pix(2'd3, 255, 128, 1, "R2 fifo 3");
    // channel swap: red out from blue in
    wr(2'd2, cw(0, 0, 256), 0);
    wr(2'd1, cw(0, 256, 0), 0);
    wr(2'd0, cw(256, 0, 0), 1);
    frame();
    pix(2'd1, 200, 100, 40, "R3 swap R/B half gain");
    pix(2'd1, 1, 3, 5, "R5 round half up");
    // negative coefficients and negative offsets
    wr(2'd2, cw(10'h200 | 300, 400, 100), 0);
    wr(2'd3, {8'h02, 8'hF0, 8'h10, 8'h80}, 0);
    frame();
    pix(2'd1, 255, 0, 0, "R4 offsets signed");
    pix(2'd1, 0, 0, 0, "R5 saturate low");
    wr(2'd2, cw(511, 511, 511), 0);
    wr(2'd1, cw(511, 511, 511), 0);
    wr(2'd0, cw(511, 511, 511), 0);
    wr(2'd3, {8'h02, 8'h7F, 8'h7F, 8'h7F}, 0);
    frame();
    pix(2'd1, 255, 255, 255, "R5 saturate high");
    wr(2'd3, {8'h82, 8'h00, 8'h00, 8'h00}, 0);
    frame();
    pix(2'd1, 255, 255, 255, "R6 clamp high");
    pix(2'd1, 0, 0, 0, "R6 clamp low");
    pix(2'd2, 0, 0, 0, "R6 clamp ignored off-fifo");
    // select 0 disables
    wr(2'd3, 32'h0000_0010, 0);
    frame();
    pix(2'd0, 17, 34, 51, "R2 select zero");
    // coincident write and frame
    wr(2'd3, 32'h0100_0000, 1);
    pix(2'd0, 17, 34, 51, "R8 coincident write deferred");
    frame();
    pix(2'd0, 17, 34, 51, "R8 coincident write after next frame");

    // random
    for (int it = 0; it < 40; it++) begin
      for (int a = 0; a < 4; a++) wr(2'(a), $urandom, 0);
      if (it % 5 == 0) pix(2'($urandom_range(0, 3)), 30, 60, 90, "R7 pre-frame");
      frame();
      for (int p = 0; p < 8; p++)
        pix(2'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "R3 R4 R5 R6 random");
    end

    // converter
    conv(64'h0000_0000_8000_0000);
    conv(64'h0000_0001_0000_0000);
    conv(64'h8000_0000_8000_0000);
    conv(64'h8000_0000_0000_0000);
    conv(64'h0000_0000_FFFF_FFFF);
    conv(64'hC000_0000_0000_0001);
    for (int k = 0; k < 20; k++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (k % 2 == 0) v[62:32] = '0;
      conv(v);
    end

    // R10 valid drops when no pixel
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 idle: got v=%0d exp v=0", out_valid);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule